// File: doc/BRIEF.md
# Cascaded Three-Segment Channel Divider

This block divides a fast input clock by one of fourteen fixed ratios, from 1 up to 192. The ratio is built by chaining three divide segments. The first segment divides by 2 or 3, or is bypassed. The second and third segments each divide by 2, 4, 6 or 8, or pass their input through (÷1). A 4-bit ratio index selects one fixed segment triple from a table inside the block.

Two output clocks, A and B, are each taken either straight from the input clock or from the divider chain. Each output has its own enable. The block also drives the decoded control picture that the surrounding logic needs:
- one enable per segment;
- a code naming the last active segment;
- the shared route select;
- the direct-path enable for each output;
- the divided-path enable for each output;
- a power-down flag for the shared divided path.

The ratio index is registered on the input clock. A change of index restarts all three segment counters together.

Top module: `chan_div_cascade`

## Requirements
- R1: Index i selects the segment triple (s1,s2,s3) and total ratio N = s1*s2*s3 as follows:
  - 0: (1,1,1), N=1
  - 1: (2,1,1), N=2
  - 2: (3,1,1), N=3
  - 3: (2,2,1), N=4
  - 4: (3,2,1), N=6
  - 5: (2,4,1), N=8
  - 6: (2,6,1), N=12
  - 7: (2,8,1), N=16
  - 8: (3,8,1), N=24
  - 9: (2,8,2), N=32
  - 10: (2,8,4), N=64
  - 11: (2,8,6), N=96
  - 12: (2,8,8), N=128
  - 13: (3,8,8), N=192

  For N>1, an enabled output has a period of exactly N input cycles.
- R2: For N>1, each output period is high for floor(N/2) input cycles and low for the remaining cycles.
- R3: With N=1, an enabled output equals the input clock in both clock phases. In this case `route_div`=0, `divdist_pd`=1, every segment enable is 0 and `seg_last`=0.
- R4: With N>1, `route_div`=1, both direct enables are 0, and `divdist_a_on`/`divdist_b_on` equal the matching output enable.
- R5: `segK_on` is 1 exactly when sK>1. `seg_last` encodes the highest active segment: 0 means none, 1 means segment 1 only, 2 means segments 1 and 2, and 3 means all three.
- R6: An output whose enable is 0 is held at 0 and has its direct and divided enables at 0. When both enables are 0, `divdist_pd`=1.
- R7: Index values 14 and 15 behave exactly as index 13.
- R8: The index is registered on the rising input edge. In the cycle after a change, a divided output is low. It rises one input cycle later and then runs at the new period with no further adjustment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Fast input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ratio_sel | input | 4 | Ratio index |
| out_a_on | input | 1 | Output A enable |
| out_b_on | input | 1 | Output B enable |
| clk_a | output | 1 | Output clock A |
| clk_b | output | 1 | Output clock B |
| seg1_on | output | 1 | Segment 1 active |
| seg2_on | output | 1 | Segment 2 active |
| seg3_on | output | 1 | Segment 3 active |
| seg_last | output | 2 | Highest active segment code |
| route_div | output | 1 | Both outputs take the divided path |
| direct_a_on | output | 1 | Undivided path to A enabled |
| direct_b_on | output | 1 | Undivided path to B enabled |
| divdist_a_on | output | 1 | Divided path to A enabled |
| divdist_b_on | output | 1 | Divided path to B enabled |
| divdist_pd | output | 1 | Shared divided path powered down |

## Verification
A segment counter that wraps at the wrong value shows up as a wrong period or a wrong high time on `clk_a`. This appears within one output period, at most 192 input cycles. A bad table entry or a bad decode also shows up immediately, on the static enables and on `seg_last`. A restart fault shows up in the first two cycles after an index change, as a missing low cycle or a late rising edge.

// File: rtl/chan_div_cascade.sv
module chan_div_cascade #(
  parameter int IDX_W = 4,
  parameter int S1_W  = 2,
  parameter int S_W   = 4,
  parameter int PH_W  = 8
) (
  input  logic             clk_in,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] ratio_sel,
  input  logic             out_a_on,
  input  logic             out_b_on,
  output logic             clk_a,
  output logic             clk_b,
  output logic             seg1_on,
  output logic             seg2_on,
  output logic             seg3_on,
  output logic [1:0]       seg_last,
  output logic             route_div,
  output logic             direct_a_on,
  output logic             direct_b_on,
  output logic             divdist_a_on,
  output logic             divdist_b_on,
  output logic             divdist_pd
);

  localparam int LAST_IDX = 13;

  logic [IDX_W-1:0] idx_q;
  logic [S1_W-1:0]  s1, c1;
  logic [S_W-1:0]   s2, s3, c2, c3;
  logic [PH_W-1:0]  phase, ratio_n, half_n;
  logic             div_q;
  logic             w1, w2, w3;

  function automatic logic [S1_W+2*S_W-1:0] seg_table(input logic [IDX_W-1:0] i);
    logic [IDX_W-1:0] k;
    k = (i > IDX_W'(LAST_IDX)) ? IDX_W'(LAST_IDX) : i;
    case (k)
      4'd0:    seg_table = {2'd1, 4'd1, 4'd1};
      4'd1:    seg_table = {2'd2, 4'd1, 4'd1};
      4'd2:    seg_table = {2'd3, 4'd1, 4'd1};
      4'd3:    seg_table = {2'd2, 4'd2, 4'd1};
      4'd4:    seg_table = {2'd3, 4'd2, 4'd1};
      4'd5:    seg_table = {2'd2, 4'd4, 4'd1};
      4'd6:    seg_table = {2'd2, 4'd6, 4'd1};
      4'd7:    seg_table = {2'd2, 4'd8, 4'd1};
      4'd8:    seg_table = {2'd3, 4'd8, 4'd1};
      4'd9:    seg_table = {2'd2, 4'd8, 4'd2};
      4'd10:   seg_table = {2'd2, 4'd8, 4'd4};
      4'd11:   seg_table = {2'd2, 4'd8, 4'd6};
      4'd12:   seg_table = {2'd2, 4'd8, 4'd8};
      default: seg_table = {2'd3, 4'd8, 4'd8};
    endcase
  endfunction

  assign {s1, s2, s3} = seg_table(idx_q);

  assign w1 = (c1 == s1 - S1_W'(1));
  assign w2 = (c2 == s2 - S_W'(1));
  assign w3 = (c3 == s3 - S_W'(1));

  assign ratio_n = PH_W'(s1) * PH_W'(s2) * PH_W'(s3);
  assign half_n  = ratio_n >> 1;
  assign phase   = PH_W'(c3) * (PH_W'(s1) * PH_W'(s2)) + PH_W'(c2) * PH_W'(s1) + PH_W'(c1);

  always_ff @(posedge clk_in) begin
    if (!rst_n) begin
      idx_q <= '0;
      c1    <= '0;
      c2    <= '0;
      c3    <= '0;
      div_q <= 1'b0;
    end else if (ratio_sel != idx_q) begin
      idx_q <= ratio_sel;
      c1    <= '0;
      c2    <= '0;
      c3    <= '0;
      div_q <= 1'b0;
    end else begin
      c1    <= w1 ? '0 : c1 + S1_W'(1);
      if (w1)
        c2  <= w2 ? '0 : c2 + S_W'(1);
      if (w1 && w2)
        c3  <= w3 ? '0 : c3 + S_W'(1);
      div_q <= (phase < half_n);
    end
  end

  assign seg1_on  = (s1 > S1_W'(1));
  assign seg2_on  = (s2 > S_W'(1));
  assign seg3_on  = (s3 > S_W'(1));
  assign seg_last = seg3_on ? 2'd3 : seg2_on ? 2'd2 : seg1_on ? 2'd1 : 2'd0;

  assign route_div    = seg1_on;
  assign direct_a_on  = !route_div && out_a_on;
  assign direct_b_on  = !route_div && out_b_on;
  assign divdist_a_on = route_div && out_a_on;
  assign divdist_b_on = route_div && out_b_on;
  assign divdist_pd   = !route_div || (!out_a_on && !out_b_on);

  assign clk_a = out_a_on && (route_div ? div_q : clk_in);
  assign clk_b = out_b_on && (route_div ? div_q : clk_in);

  p_cnt_range_r1: assert property (@(posedge clk_in) disable iff (!rst_n)
    (c1 < s1) && (c2 < s2) && (c3 < s3));

  p_route_excl_r4: assert property (@(posedge clk_in) disable iff (!rst_n)
    route_div |-> (!direct_a_on && !direct_b_on && !divdist_pd || (!out_a_on && !out_b_on)));

  p_seg_chain_r5: assert property (@(posedge clk_in) disable iff (!rst_n)
    (seg3_on |-> seg2_on) and (seg2_on |-> seg1_on));

  p_both_off_r6: assert property (@(posedge clk_in) disable iff (!rst_n)
    (!out_a_on && !out_b_on) |-> (divdist_pd && !clk_a && !clk_b));

  p_restart_r8: assert property (@(posedge clk_in) disable iff (!rst_n)
    (idx_q != $past(idx_q)) |-> (c1 == '0 && c2 == '0 && c3 == '0 && !div_q));

  p_rise_after_change_r8: assert property (@(posedge clk_in) disable iff (!rst_n)
    ((idx_q != $past(idx_q)) && (ratio_sel == idx_q) && seg1_on) |=> div_q);

endmodule

// File: tb/chan_div_cascade_tb.sv
`timescale 1ns/1ps
module chan_div_cascade_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] ratio_sel = 4'd0;
  logic out_a_on = 1'b1, out_b_on = 1'b1;
  logic clk_a, clk_b, seg1_on, seg2_on, seg3_on, route_div;
  logic direct_a_on, direct_b_on, divdist_a_on, divdist_b_on, divdist_pd;
  logic [1:0] seg_last;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  chan_div_cascade dut_i (
    .clk_in(clk), .rst_n(rst_n), .ratio_sel(ratio_sel), .out_a_on(out_a_on), .out_b_on(out_b_on),
    .clk_a(clk_a), .clk_b(clk_b), .seg1_on(seg1_on), .seg2_on(seg2_on), .seg3_on(seg3_on),
    .seg_last(seg_last), .route_div(route_div), .direct_a_on(direct_a_on), .direct_b_on(direct_b_on),
    .divdist_a_on(divdist_a_on), .divdist_b_on(divdist_b_on), .divdist_pd(divdist_pd));

  function automatic int s1_of(input int i);
    int t[14] = '{1,2,3,2,3,2,2,2,3,2,2,2,2,3};
    return t[(i > 13) ? 13 : i];
  endfunction
  function automatic int s2_of(input int i);
    int t[14] = '{1,1,1,2,2,4,6,8,8,8,8,8,8,8};
    return t[(i > 13) ? 13 : i];
  endfunction
  function automatic int s3_of(input int i);
    int t[14] = '{1,1,1,1,1,1,1,1,1,2,4,6,8,8};
    return t[(i > 13) ? 13 : i];
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_idx(input int i);
    @(negedge clk);
    ratio_sel = 4'(i);
  endtask

  task automatic measure(input string req, input int n);
    int hi = 0, lo = 0, guard = 0;
    repeat (2 * n + 4) @(negedge clk);
    #1;
    while (clk_a == 1'b1 && guard < 1000) begin @(negedge clk); #1; guard++; end
    while (clk_a == 1'b0 && guard < 1000) begin @(negedge clk); #1; guard++; end
    while (clk_a == 1'b1 && guard < 1000) begin hi++; @(negedge clk); #1; guard++; end
    while (clk_a == 1'b0 && guard < 1000) begin lo++; @(negedge clk); #1; guard++; end
    chk({req, " period"}, hi + lo, n);
    chk({req, " high"}, hi, n / 2);
  endtask

  task automatic test_reset;
    chk("R3 reset route_div", int'(route_div), 0);
    chk("R3 reset seg_last", int'(seg_last), 0);
    chk("R3 reset divdist_pd", int'(divdist_pd), 1);
  endtask

  task automatic test_decode_and_period;
    for (int i = 0; i < 16; i++) begin
      int a = s1_of(i), b = s2_of(i), c = s3_of(i);
      int n = a * b * c;
      int last = (c > 1) ? 3 : (b > 1) ? 2 : (a > 1) ? 1 : 0;
      set_idx(i);
      @(negedge clk); #1;
      chk((i > 13) ? "R7 seg1_on" : "R5 seg1_on", int'(seg1_on), int'(a > 1));
      chk("R5 seg2_on", int'(seg2_on), int'(b > 1));
      chk("R5 seg3_on", int'(seg3_on), int'(c > 1));
      chk("R5 seg_last", int'(seg_last), last);
      if (n == 1) begin
        chk("R3 route_div", int'(route_div), 0);
        chk("R3 direct_a_on", int'(direct_a_on), 1);
        chk("R3 divdist_pd", int'(divdist_pd), 1);
        @(posedge clk); #1;
        chk("R3 clk_a high phase", int'(clk_a), 1);
        chk("R3 clk_b high phase", int'(clk_b), 1);
        @(negedge clk); #1;
        chk("R3 clk_a low phase", int'(clk_a), 0);
      end else begin
        chk("R4 route_div", int'(route_div), 1);
        chk("R4 direct_a_on", int'(direct_a_on), 0);
        chk("R4 divdist_b_on", int'(divdist_b_on), 1);
        chk("R4 divdist_pd", int'(divdist_pd), 0);
        measure((i > 13) ? "R7 alias" : "R1/R2 ratio", n);
      end
    end
  endtask

  task automatic test_enables;
    set_idx(5);
    out_a_on = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R6 A off divdist_a_on", int'(divdist_a_on), 0);
    chk("R6 B on divdist_b_on", int'(divdist_b_on), 1);
    chk("R6 one off divdist_pd", int'(divdist_pd), 0);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); #1;
      chk("R6 clk_a held", int'(clk_a), 0);
    end
    out_b_on = 1'b0;
    #1;
    chk("R6 both off divdist_pd", int'(divdist_pd), 1);
    chk("R6 clk_b held", int'(clk_b), 0);
    set_idx(0);
    @(posedge clk); #1;
    chk("R6 bypass clk_a held", int'(clk_a), 0);
    chk("R6 bypass direct_a_on", int'(direct_a_on), 0);
    out_a_on = 1'b1;
    out_b_on = 1'b1;
  endtask

  task automatic test_change;
    set_idx(13);
    repeat (150) @(negedge clk);
    ratio_sel = 4'd2;
    @(negedge clk); #1;
    chk("R8 low after change", int'(clk_a), 0);
    @(negedge clk); #1;
    chk("R8 rise after change", int'(clk_a), 1);
    @(negedge clk); #1;
    chk("R8 new ratio low", int'(clk_a), 0);
    @(negedge clk); #1;
    chk("R8 new ratio low 2", int'(clk_a), 0);
    @(negedge clk); #1;
    chk("R8 new ratio rise", int'(clk_a), 1);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    test_reset();
    test_decode_and_period();
    test_enables();
    test_change();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule